// File: doc/BRIEF.md
# Real-Time Clock Day/Time Counter with Alarm

This block keeps wall-clock time for a chip. A slow reference clock arrives as a one-cycle strobe in the system clock domain. A prescaler turns those strobes into sub-second ticks and then into a one-second tick. The input rate comes from one of three selectable values. Each second advances a cascade of second, minute, hour and day counters.

A host reaches every counter and the alarm values over a simple 16-bit register port with a 6-bit byte address. Writes take effect on the next clock edge. Reads come straight from the registers, with no added wait states. Hour and minute share one register, with the hour in bits 12:8 and the minute in bits 5:0. Seconds and the day count each have a register of their own.

The alarm is a full day/hour/minute/second match. Two events are reported, both as one-cycle pulses at the ports and as sticky status bits. The first is the alarm event. The second is the once-per-second event.

Top module: `rtc_core`

## Requirements
- R1: After reset, every time, alarm, control and status register reads 0, and both event outputs are low.
- R2: The control register (address 0x10) holds the run enable in bit 7 and the rate select in bits 6:5. A read returns exactly those bits, and all other bits read 0.
- R3: With run enabled, one second elapses every RATE0 reference strobes for select code 0, every RATE1 strobes for code 1, and every RATE2 strobes for code 2. Code 3 behaves as code 0. The sub-second steps use fractional accumulation, so a rate that is not a multiple of SUB_HZ still gives exact seconds.
- R4: `sec_evt` is high for one cycle, in the cycle after the clock edge at which the seconds value advanced. Status bit 4 (address 0x14) becomes 1 one cycle later and stays set.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day count.
- R6: The day count (address 0x20) is DAY_W bits wide and wraps from 2^DAY_W-1 to 0.
- R7: Writes to hour/minute (0x00, hour in bits 12:8, minute in bits 5:0), seconds (0x04, bits 5:0) and day (0x20) read back from the cycle after the write. A second boundary that falls on the edge of such a write is dropped.
- R8: A write to the seconds register restarts the prescaler, so the next second comes a full period of strobes after the write.
- R9: The alarm registers are hour/minute (0x08), seconds (0x0C) and day (0x24). `alarm_evt` pulses together with `sec_evt` when the newly reached day, hour, minute and second all equal the alarm registers. Status bit 2 becomes 1 one cycle later and stays set.
- R10: While the run enable is 0, reference strobes are ignored, and the counters and the prescaler keep their values.
- R11: Writing a 1 to status bit 2 or bit 4 clears that bit. Writing a 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sec_evt | output | 1 | One-cycle once-per-second event |
| alarm_evt | output | 1 | One-cycle alarm match event |

## Verification
A wrong prescaler phase shows up as `sec_evt` arriving early or late against the counted strobes. That is visible within one second's worth of strobes. A wrong carry or wrap shows up in the hour/minute or day readback on the very cycle after the boundary edge. A wrong alarm compare shows up as `alarm_evt` missing, or appearing, in the cycle of the matching second. Because the bench compares the events and the addressed readback on every clock, each of these faults is caught in the first cycle in which it can be seen.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam logic [5:0] ADR_HM    = 6'h00;
   localparam logic [5:0] ADR_SEC   = 6'h04;
   localparam logic [5:0] ADR_AHM   = 6'h08;
   localparam logic [5:0] ADR_ASEC  = 6'h0C;
   localparam logic [5:0] ADR_CTL   = 6'h10;
   localparam logic [5:0] ADR_STS   = 6'h14;
   localparam logic [5:0] ADR_DAY   = 6'h20;
   localparam logic [5:0] ADR_ADAY  = 6'h24;

   localparam int STS_ALM_BIT = 2;
   localparam int STS_SEC_BIT = 4;
   localparam int CTL_RUN_BIT = 7;
   localparam int CTL_SEL_LSB = 5;

   localparam int SEC_W = 6;
   localparam int MIN_W = 6;
   localparam int HR_W  = 5;

   typedef struct packed {
      logic [HR_W-1:0]  hr;
      logic [MIN_W-1:0] mn;
      logic [SEC_W-1:0] sec;
   } tod_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int SUB_HZ = 1024,
   parameter int RATE0  = 32768,
   parameter int RATE1  = 32000,
   parameter int RATE2  = 38400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       ref_pulse,
   input  logic       clear,
   input  logic [1:0] sel,
   output logic       sec_tick
);
   localparam int MAXR01 = (RATE0 > RATE1) ? RATE0 : RATE1;
   localparam int MAXR   = (MAXR01 > RATE2) ? MAXR01 : RATE2;
   localparam int ACC_W  = $clog2(MAXR + SUB_HZ + 1);
   localparam int SUB_W  = (SUB_HZ > 1) ? $clog2(SUB_HZ) : 1;

   if (SUB_HZ < 1) begin : g_bad_sub
      $error("SUB_HZ must be at least 1");
   end
   if (RATE0 < SUB_HZ || RATE1 < SUB_HZ || RATE2 < SUB_HZ) begin : g_bad_rate
      $error("every rate must be at least SUB_HZ");
   end

   logic [ACC_W-1:0] rate_tab [4];
   for (genvar g = 0; g < 4; g++) begin : g_rate
      localparam int R = (g == 1) ? RATE1 : (g == 2) ? RATE2 : RATE0;
      assign rate_tab[g] = ACC_W'(R);
   end

   logic [ACC_W-1:0] acc_q;
   logic [SUB_W-1:0] subc_q;
   logic [ACC_W-1:0] rate;
   logic [ACC_W-1:0] sum;
   logic             step;
   logic             sub_hit;
   logic             sub_last;

   always_comb begin
      rate     = rate_tab[sel];
      sum      = acc_q + ACC_W'(SUB_HZ);
      step     = run & ref_pulse;
      sub_hit  = step & (sum >= rate);
      sub_last = (subc_q == SUB_W'(SUB_HZ - 1));
      sec_tick = sub_hit & sub_last & ~clear;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc_q  <= '0;
         subc_q <= '0;
      end else if (step) begin
         acc_q <= sub_hit ? (sum - rate) : sum;
         if (sub_hit) begin
            subc_q <= sub_last ? '0 : subc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_wrapctr.sv
module rtc_wrapctr #(
   parameter int W    = 6,
   parameter int LAST = 59
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q,
   output logic         carry
);
   if (W < 1 || W > 32) begin : g_bad_w
      $error("counter width out of range");
   end

   assign carry = inc & (q == W'(LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (inc) begin
         q <= carry ? '0 : q + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import rtc_pkg::*;
#(
   parameter int DAY_W  = 16,
   parameter int SUB_HZ = 1024,
   parameter int RATE0  = 32768,
   parameter int RATE1  = 32000,
   parameter int RATE2  = 38400
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ref_pulse,
   input  logic        bus_wr,
   input  logic [5:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        sec_evt,
   output logic        alarm_evt
);
   localparam int DAY_LAST = (1 << DAY_W) - 1;

   if (DAY_W < 1 || DAY_W > 16) begin : g_bad_day
      $error("DAY_W must lie in 1..16");
   end

   logic wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday, wr_ctl, wr_sts;
   always_comb begin
      wr_hm   = bus_wr && bus_addr == ADR_HM;
      wr_sec  = bus_wr && bus_addr == ADR_SEC;
      wr_day  = bus_wr && bus_addr == ADR_DAY;
      wr_ahm  = bus_wr && bus_addr == ADR_AHM;
      wr_asec = bus_wr && bus_addr == ADR_ASEC;
      wr_aday = bus_wr && bus_addr == ADR_ADAY;
      wr_ctl  = bus_wr && bus_addr == ADR_CTL;
      wr_sts  = bus_wr && bus_addr == ADR_STS;
   end

   logic       en;
   logic [1:0] sel;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en  <= 1'b0;
         sel <= 2'd0;
      end else if (wr_ctl) begin
         en  <= bus_wdata[CTL_RUN_BIT];
         sel <= bus_wdata[CTL_SEL_LSB +: 2];
      end
   end

   logic sec_tick, tick, time_wr;
   assign time_wr = wr_hm | wr_sec | wr_day;
   assign tick    = sec_tick & ~time_wr;

   rtc_prescaler #(
      .SUB_HZ(SUB_HZ), .RATE0(RATE0), .RATE1(RATE1), .RATE2(RATE2)
   ) u_presc (
      .clk(clk), .rst_n(rst_n), .run(en), .ref_pulse(ref_pulse),
      .clear(wr_sec), .sel(sel), .sec_tick(sec_tick)
   );

   tod_t             now;
   logic [DAY_W-1:0] day_q;
   logic             sec_cy, min_cy, hr_cy, day_cy;

   rtc_wrapctr #(.W(SEC_W), .LAST(59)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(tick), .ld(wr_sec),
      .ld_val(bus_wdata[SEC_W-1:0]), .q(now.sec), .carry(sec_cy)
   );
   rtc_wrapctr #(.W(MIN_W), .LAST(59)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(sec_cy), .ld(wr_hm),
      .ld_val(bus_wdata[MIN_W-1:0]), .q(now.mn), .carry(min_cy)
   );
   rtc_wrapctr #(.W(HR_W), .LAST(23)) u_hr (
      .clk(clk), .rst_n(rst_n), .inc(min_cy), .ld(wr_hm),
      .ld_val(bus_wdata[8 +: HR_W]), .q(now.hr), .carry(hr_cy)
   );
   rtc_wrapctr #(.W(DAY_W), .LAST(DAY_LAST)) u_day (
      .clk(clk), .rst_n(rst_n), .inc(hr_cy), .ld(wr_day),
      .ld_val(bus_wdata[DAY_W-1:0]), .q(day_q), .carry(day_cy)
   );

   tod_t             alm;
   logic [DAY_W-1:0] alm_day;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm     <= '0;
         alm_day <= '0;
      end else begin
         if (wr_ahm) begin
            alm.hr <= bus_wdata[8 +: HR_W];
            alm.mn <= bus_wdata[MIN_W-1:0];
         end
         if (wr_asec) alm.sec <= bus_wdata[SEC_W-1:0];
         if (wr_aday) alm_day <= bus_wdata[DAY_W-1:0];
      end
   end

   logic match;
   assign match     = (now == alm) && (day_q == alm_day);
   assign alarm_evt = sec_evt & match;

   logic sts_alm, sts_sec;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_evt <= 1'b0;
         sts_alm <= 1'b0;
         sts_sec <= 1'b0;
      end else begin
         sec_evt <= tick;
         if (alarm_evt) sts_alm <= 1'b1;
         else if (wr_sts && bus_wdata[STS_ALM_BIT]) sts_alm <= 1'b0;
         if (sec_evt) sts_sec <= 1'b1;
         else if (wr_sts && bus_wdata[STS_SEC_BIT]) sts_sec <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_HM: begin
            bus_rdata[8 +: HR_W]    = now.hr;
            bus_rdata[MIN_W-1:0]    = now.mn;
         end
         ADR_SEC:  bus_rdata[SEC_W-1:0] = now.sec;
         ADR_AHM: begin
            bus_rdata[8 +: HR_W]    = alm.hr;
            bus_rdata[MIN_W-1:0]    = alm.mn;
         end
         ADR_ASEC: bus_rdata[SEC_W-1:0] = alm.sec;
         ADR_CTL: begin
            bus_rdata[CTL_RUN_BIT]       = en;
            bus_rdata[CTL_SEL_LSB +: 2]  = sel;
         end
         ADR_STS: begin
            bus_rdata[STS_ALM_BIT] = sts_alm;
            bus_rdata[STS_SEC_BIT] = sts_sec;
         end
         ADR_DAY:  bus_rdata[DAY_W-1:0] = day_q;
         ADR_ADAY: bus_rdata[DAY_W-1:0] = alm_day;
         default:  bus_rdata = '0;
      endcase
   end

   logic unused_day_cy;
   assign unused_day_cy = day_cy;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
   import rtc_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             bus_wr,
   input logic [5:0]       bus_addr,
   input logic [15:0]      bus_wdata,
   input logic             sec_evt,
   input logic             alarm_evt,
   input logic             sts_alm,
   input logic             sts_sec,
   input tod_t             now,
   input logic [DAY_W-1:0] day_q
);
   assert_alarm_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> sec_evt);

   assert_alarm_sets_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> sts_alm);

   assert_sec_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_evt |=> sts_sec);

   assert_sec_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_evt |=> !sec_evt);

   assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !bus_wr) |=> ($stable(now) && $stable(day_q) && !sec_evt));

   assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_evt |-> (now.sec == (($past(now.sec) == 6'd59) ? 6'd0 : $past(now.sec) + 6'd1)));

   assert_sec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_SEC) |=> (now.sec == $past(bus_wdata[SEC_W-1:0])));
endmodule

bind rtc_core rtc_core_chk #(.DAY_W(DAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .sec_evt(sec_evt), .alarm_evt(alarm_evt),
   .sts_alm(sts_alm), .sts_sec(sts_sec), .now(now), .day_q(day_q)
);

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;
   localparam int DAY_W = 9;
   localparam int SUBH  = 4;
   localparam int R0 = 12, R1 = 10, R2 = 14;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        ref_pulse = 0;
   logic        bus_wr = 0;
   logic [5:0]  bus_addr = 0;
   logic [15:0] bus_wdata = 0;
   logic [15:0] bus_rdata;
   logic        sec_evt, alarm_evt;

   rtc_core #(.DAY_W(DAY_W), .SUB_HZ(SUBH), .RATE0(R0), .RATE1(R1), .RATE2(R2)) u_rtc_core (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sec_evt(sec_evt), .alarm_evt(alarm_evt)
   );

   always #2.5 clk = ~clk;

   int errors = 0, checks = 0;
   int total_alm = 0;
   bit done = 0;

   // behavioural reference state
   int m_sec, m_mn, m_hr, m_day, a_sec, a_mn, a_hr, a_day;
   int m_en, m_sel, m_ps, m_secevt, s_alm, s_sec;

   function automatic bit m_match();
      return m_sec == a_sec && m_mn == a_mn && m_hr == a_hr && m_day == a_day;
   endfunction

   function automatic int m_read(input int a);
      case (a)
         'h00: return (m_hr << 8) | m_mn;
         'h04: return m_sec;
         'h08: return (a_hr << 8) | a_mn;
         'h0C: return a_sec;
         'h10: return (m_en << 7) | (m_sel << 5);
         'h14: return (s_sec << 4) | (s_alm << 2);
         'h20: return m_day;
         'h24: return a_day;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         'h10: return "R2";
         'h14: return "R11";
         'h08, 'h0C, 'h24: return "R9";
         default: return "R7";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_mn = 0; m_hr = 0; m_day = 0;
         a_sec = 0; a_mn = 0; a_hr = 0; a_day = 0;
         m_en = 0; m_sel = 0; m_ps = 0; m_secevt = 0; s_alm = 0; s_sec = 0;
      end else begin : step
         bit w_hm, w_sec, w_day, st, tk, old_alm, old_sec;
         int rate;
         w_hm  = bus_wr && bus_addr == 6'h00;
         w_sec = bus_wr && bus_addr == 6'h04;
         w_day = bus_wr && bus_addr == 6'h20;
         rate  = (m_sel == 1) ? R1 : (m_sel == 2) ? R2 : R0;
         old_alm = m_secevt && m_match();
         old_sec = m_secevt;
         st = 0;
         if (w_sec) m_ps = 0;
         else if (m_en != 0 && ref_pulse) begin
            m_ps++;
            if (m_ps == rate) begin m_ps = 0; st = 1; end
         end
         tk = st && !(w_hm || w_sec || w_day);
         if (tk) begin
            m_sec++;
            if (m_sec == 60) begin
               m_sec = 0; m_mn++;
               if (m_mn == 60) begin
                  m_mn = 0; m_hr++;
                  if (m_hr == 24) begin m_hr = 0; m_day = (m_day + 1) % (1 << DAY_W); end
               end
            end
         end
         if (bus_wr) begin
            case (bus_addr)
               6'h00: begin m_hr = bus_wdata[12:8]; m_mn = bus_wdata[5:0]; end
               6'h04: m_sec = bus_wdata[5:0];
               6'h20: m_day = bus_wdata[DAY_W-1:0];
               6'h08: begin a_hr = bus_wdata[12:8]; a_mn = bus_wdata[5:0]; end
               6'h0C: a_sec = bus_wdata[5:0];
               6'h24: a_day = bus_wdata[DAY_W-1:0];
               6'h10: begin m_en = bus_wdata[7]; m_sel = bus_wdata[6:5]; end
               default: ;
            endcase
         end
         if (old_alm) s_alm = 1;
         else if (bus_wr && bus_addr == 6'h14 && bus_wdata[2]) s_alm = 0;
         if (old_sec) s_sec = 1;
         else if (bus_wr && bus_addr == 6'h14 && bus_wdata[4]) s_sec = 0;
         m_secevt = tk;
      end
   end

   // per-clock comparison against the reference model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (sec_evt !== m_secevt[0]) begin
            errors++;
            $display("FAIL R4 sec_evt actual=%0b expected=%0b", sec_evt, m_secevt[0]);
         end
         checks++;
         if (alarm_evt !== (m_secevt != 0 && m_match())) begin
            errors++;
            $display("FAIL R9 alarm_evt actual=%0b expected=%0b", alarm_evt, m_secevt != 0 && m_match());
         end
         checks++;
         if (bus_rdata !== 16'(m_read(bus_addr))) begin
            errors++;
            $display("FAIL %s rdata@%0h actual=%0h expected=%0h", tag_of(bus_addr), bus_addr,
                     bus_rdata, m_read(bus_addr));
         end
         if (alarm_evt) total_alm++;
      end
   end

   task automatic idle(input int n, input bit rp);
      repeat (n) begin
         ref_pulse = rp;
         @(posedge clk); #1;
      end
      ref_pulse = 0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
      bus_addr = a;
      #0.5;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s read@%0h actual=%0h expected=%0h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      #50000;
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int a0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      foreach (rtc_pkg_addrs[i]) rd(rtc_pkg_addrs[i], 16'h0000, "R1");
      chk(!sec_evt && !alarm_evt, "R1 events", sec_evt, 0);
      // R2: control readback
      wr(6'h10, 16'h00E0); rd(6'h10, 16'h00E0, "R2");
      // R3: rates per select code
      for (int code = 0; code < 4; code++) begin
         int r;
         r = (code == 1) ? R1 : (code == 2) ? R2 : R0;
         wr(6'h10, 16'(16'h0080 | (code << 5)));
         wr(6'h04, 16'd0);
         idle(5 * r, 1);
         rd(6'h04, 16'd5, "R3");
      end
      // R3 with sparse strobes, code 1 (fractional)
      wr(6'h10, 16'h00A0); wr(6'h04, 16'd0);
      for (int k = 0; k < 3 * R1; k++) begin idle(1, 1); idle(2, 0); end
      rd(6'h04, 16'd3, "R3");
      wr(6'h10, 16'h0080);
      // R8: seconds write restarts the prescaler
      wr(6'h04, 16'd10); idle(7, 1);
      wr(6'h04, 16'd20); idle(R0 - 1, 1);
      rd(6'h04, 16'd20, "R8");
      idle(1, 1);
      rd(6'h04, 16'd21, "R8");
      // R7: hour/minute readback, tick dropped on a write edge
      wr(6'h04, 16'd30); idle(R0 - 1, 1);
      ref_pulse = 1; wr(6'h00, 16'h0C22); ref_pulse = 0;
      rd(6'h00, 16'h0C22, "R7");
      rd(6'h04, 16'd30, "R7");
      // R5: minute and day carries
      wr(6'h00, 16'h0A3B); wr(6'h04, 16'd59); idle(R0, 1);
      rd(6'h00, 16'h0B00, "R5");
      wr(6'h20, 16'd5); wr(6'h00, 16'h173B); wr(6'h04, 16'd58); idle(2 * R0, 1);
      rd(6'h00, 16'h0000, "R5"); rd(6'h20, 16'd6, "R5");
      // R6: day wrap at DAY_W
      wr(6'h20, 16'd511); wr(6'h00, 16'h173B); wr(6'h04, 16'd59); idle(R0, 1);
      rd(6'h20, 16'd0, "R6");
      // R9: alarm match and day granularity
      wr(6'h14, 16'h0014);
      wr(6'h08, 16'h0001); wr(6'h0C, 16'd2); wr(6'h24, 16'd3);
      wr(6'h20, 16'd3); wr(6'h00, 16'h0001); wr(6'h04, 16'd0);
      a0 = total_alm;
      idle(4 * R0, 1); idle(1, 0);
      chk(total_alm - a0 == 1, "R9 alarm count", total_alm - a0, 1);
      rd(6'h14, 16'h0014, "R9");
      // R11: write-one-to-clear
      wr(6'h14, 16'h0004); rd(6'h14, 16'h0010, "R11");
      wr(6'h14, 16'h0000); rd(6'h14, 16'h0010, "R11");
      wr(6'h24, 16'd4); wr(6'h00, 16'h0001); wr(6'h04, 16'd0);
      a0 = total_alm;
      idle(4 * R0, 1); idle(1, 0);
      chk(total_alm == a0, "R9 day mismatch", total_alm - a0, 0);
      // R10: disabled hold
      wr(6'h04, 16'd40); idle(5, 1);
      wr(6'h10, 16'h0000); idle(100, 1);
      rd(6'h04, 16'd40, "R10");
      wr(6'h10, 16'h0080); idle(R0 - 6, 1);
      rd(6'h04, 16'd40, "R10");
      idle(1, 1);
      rd(6'h04, 16'd41, "R10");
      idle(3, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   logic [5:0] rtc_pkg_addrs [8] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h20, 6'h24};
endmodule